// File: doc/BRIEF.md
# Stage Slot Register with Hold, Void and Prime Controls

This block is the storage element placed between two neighbouring stages of an instruction pipeline. On every clock it picks its next contents from one of four places. It can take the word offered by the stage before it. It can keep what it already holds. It can load a fixed empty slot that means "no instruction here". It can also load a fixed starting word that puts the pipeline into a known state before a check begins. Each slot carries a payload, an instruction code and a short status code. The status code lets later stages tell an empty slot from a real instruction. The block exposes that test directly as an empty flag.

The hazard logic elsewhere drives the three control pins, and this block does not decide when to use them. It only fixes how they rank against each other. Back-pressure works as follows. Holding `stall_i` high freezes the slot, so the upstream stage must keep its word steady and repeat it until the stall is released. The word offered while the slot is frozen is dropped. Raising `bubble_i` throws away both the held word and the offered word, and the slot becomes empty. The data pins use no valid/ready pair, because the status field already marks whether a slot is real.

Top module: `stage_slot_reg`

## Requirements
- R1: On a clock edge with `rst` high, the slot becomes the empty word. The status is `STAT_BUBBLE`, the instruction code is `ICODE_NOP`, the payload is `VOID_PAYLOAD`, and `empty_o` is 1.
- R2: With `init_i`, `bubble_i` and `stall_i` all low, the outputs show, one edge later, the status, code and payload that were presented on the inputs.
- R3: With `stall_i` high and `bubble_i` and `init_i` low, the outputs keep their value across the edge, whatever the data inputs carry.
- R4: With `bubble_i` high and `init_i` low, the slot becomes the empty word of R1 at the next edge.
- R5: When `bubble_i` and `stall_i` are both high and `init_i` is low, the empty word is loaded and the stall has no effect.
- R6: With `init_i` high, the slot loads the start word (`INIT_STATUS`, `INIT_ICODE`, `INIT_PAYLOAD`) at the next edge. This holds whatever `bubble_i`, `stall_i` and the data inputs carry.
- R7: `empty_o` is 1 exactly when `q_status_o` equals `STAT_BUBBLE`. This also holds when a word carrying that status is captured from upstream.
- R8: `rst` ranks above every control input. With `rst` and `init_i` both high, the empty word is loaded and the start word is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Keep the current slot contents |
| bubble_i | input | 1 | Load the empty slot word |
| init_i | input | 1 | Load the start word |
| d_status_i | input | STAT_W (2) | Status code from the upstream stage |
| d_icode_i | input | ICODE_W (4) | Instruction code from the upstream stage |
| d_payload_i | input | PAYLOAD_W (32) | Payload from the upstream stage |
| q_status_o | output | STAT_W (2) | Held status code |
| q_icode_o | output | ICODE_W (4) | Held instruction code |
| q_payload_o | output | PAYLOAD_W (32) | Held payload |
| empty_o | output | 1 | High when the held status is the empty code |

## Verification
The bench builds the block with a 12-bit payload and the empty status set to code 2. The empty payload is 0xA5A and the start word is status 0, code 5 and payload 0x3C3. None of the three constant words can be mistaken for another one or for an all-zero value. These values let the bench tell each of the four next-value sources apart in every field, so a swapped priority or a wrong constant shows up at the outputs. Captured words carry the empty status code, so the empty flag has to follow the status field itself and not the control pin that loaded it.

// File: rtl/slot_pkg.sv
package slot_pkg;

  // Which of the four candidates becomes the next slot contents.
  typedef enum logic [1:0] {
    SRC_TAKE  = 2'd0,  // word from the upstream stage
    SRC_KEEP  = 2'd1,  // current contents
    SRC_VOID  = 2'd2,  // empty slot word
    SRC_PRIME = 2'd3   // start word
  } src_e;

  typedef struct packed {
    logic prime;
    logic void_req;
    logic keep;
  } ctl_t;

  localparam int unsigned N_SRC = 4;

endpackage

// File: rtl/slot_sel.sv
module slot_sel
  import slot_pkg::*;
(
  input  ctl_t ctl,
  output src_e src
);

  // Ranking: prime, then void, then keep, then take.
  always_comb begin
    if (ctl.prime)         src = SRC_PRIME;
    else if (ctl.void_req) src = SRC_VOID;
    else if (ctl.keep)     src = SRC_KEEP;
    else                   src = SRC_TAKE;
  end

endmodule

// File: rtl/slot_mux.sv
module slot_mux
  import slot_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  src_e         src,
  input  logic [W-1:0] take_w,
  input  logic [W-1:0] keep_w,
  input  logic [W-1:0] void_w,
  input  logic [W-1:0] prime_w,
  output logic [W-1:0] nxt_w
);

  logic [W-1:0] cand [N_SRC];

  assign cand[SRC_TAKE]  = take_w;
  assign cand[SRC_KEEP]  = keep_w;
  assign cand[SRC_VOID]  = void_w;
  assign cand[SRC_PRIME] = prime_w;

  assign nxt_w = cand[src];

endmodule

// File: rtl/slot_bank.sv
module slot_bank #(
  parameter int unsigned      W       = 8,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] nxt_w,
  output logic [W-1:0] q_w
);

  always_ff @(posedge clk) begin
    if (rst) q_w <= RST_VAL;
    else     q_w <= nxt_w;
  end

  // R1 / R8: reset forces the reset word regardless of the next-value path
  p_reset_word_r1: assert property (@(posedge clk) rst |=> (q_w == RST_VAL));

endmodule

// File: rtl/stage_slot_reg.sv
module stage_slot_reg
  import slot_pkg::*;
#(
  parameter int unsigned          PAYLOAD_W    = 32,
  parameter int unsigned          ICODE_W      = 4,
  parameter int unsigned          STAT_W       = 2,
  parameter logic [STAT_W-1:0]    STAT_BUBBLE  = 2'd1,
  parameter logic [ICODE_W-1:0]   ICODE_NOP    = 4'd1,
  parameter logic [PAYLOAD_W-1:0] VOID_PAYLOAD = '0,
  parameter logic [STAT_W-1:0]    INIT_STATUS  = 2'd0,
  parameter logic [ICODE_W-1:0]   INIT_ICODE   = 4'd0,
  parameter logic [PAYLOAD_W-1:0] INIT_PAYLOAD = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stall_i,
  input  logic                 bubble_i,
  input  logic                 init_i,
  input  logic [STAT_W-1:0]    d_status_i,
  input  logic [ICODE_W-1:0]   d_icode_i,
  input  logic [PAYLOAD_W-1:0] d_payload_i,
  output logic [STAT_W-1:0]    q_status_o,
  output logic [ICODE_W-1:0]   q_icode_o,
  output logic [PAYLOAD_W-1:0] q_payload_o,
  output logic                 empty_o
);

  localparam int unsigned W = STAT_W + ICODE_W + PAYLOAD_W;
  localparam logic [W-1:0] VOID_WORD  = {STAT_BUBBLE, ICODE_NOP, VOID_PAYLOAD};
  localparam logic [W-1:0] PRIME_WORD = {INIT_STATUS, INIT_ICODE, INIT_PAYLOAD};

  ctl_t         ctl;
  src_e         src;
  logic [W-1:0] d_word;
  logic [W-1:0] q_word;
  logic [W-1:0] nxt_word;

  assign ctl    = '{prime: init_i, void_req: bubble_i, keep: stall_i};
  assign d_word = {d_status_i, d_icode_i, d_payload_i};

  slot_sel u_sel (
    .ctl (ctl),
    .src (src)
  );

  slot_mux #(.W(W)) u_mux (
    .src     (src),
    .take_w  (d_word),
    .keep_w  (q_word),
    .void_w  (VOID_WORD),
    .prime_w (PRIME_WORD),
    .nxt_w   (nxt_word)
  );

  slot_bank #(.W(W), .RST_VAL(VOID_WORD)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .nxt_w (nxt_word),
    .q_w   (q_word)
  );

  assign {q_status_o, q_icode_o, q_payload_o} = q_word;
  assign empty_o = (q_status_o == STAT_BUBBLE);

  // R2: with no control active the offered word appears one edge later
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (!init_i && !bubble_i && !stall_i) |=>
      ({q_status_o, q_icode_o, q_payload_o} ==
       $past({d_status_i, d_icode_i, d_payload_i})));

  // R3: a lone stall keeps every output field
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (stall_i && !bubble_i && !init_i) |=>
      ($stable(q_status_o) && $stable(q_icode_o) && $stable(q_payload_o)));

  // R4: void request loads the empty word
  p_void_r4: assert property (@(posedge clk) disable iff (rst)
    (bubble_i && !init_i) |=>
      (q_status_o == STAT_BUBBLE && q_icode_o == ICODE_NOP &&
       q_payload_o == VOID_PAYLOAD));

  // R5: void beats stall, so the slot ends up empty
  p_void_over_stall_r5: assert property (@(posedge clk) disable iff (rst)
    (bubble_i && stall_i && !init_i) |=> empty_o);

  // R6: start word wins over every other control
  p_prime_r6: assert property (@(posedge clk) disable iff (rst)
    init_i |=>
      (q_status_o == INIT_STATUS && q_icode_o == INIT_ICODE &&
       q_payload_o == INIT_PAYLOAD));

endmodule

// File: tb/sim_stage_slot_reg.sv
module sim_stage_slot_reg;

  localparam int CLK_P = 10;
  localparam int PW = 12;
  localparam int IW = 4;
  localparam int SW = 2;
  localparam int W  = SW + IW + PW;

  localparam logic [SW-1:0] S_BUB   = 2'd2;
  localparam logic [IW-1:0] I_NOP   = 4'h1;
  localparam logic [PW-1:0] P_VOID  = 12'hA5A;
  localparam logic [SW-1:0] S_INIT  = 2'd0;
  localparam logic [IW-1:0] I_INIT  = 4'h5;
  localparam logic [PW-1:0] P_INIT  = 12'h3C3;
  localparam logic [W-1:0]  VOID_W  = {S_BUB, I_NOP, P_VOID};
  localparam logic [W-1:0]  PRIME_W = {S_INIT, I_INIT, P_INIT};

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic stall_i = 1'b0, bubble_i = 1'b0, init_i = 1'b0;
  logic [SW-1:0] d_status_i = '0;
  logic [IW-1:0] d_icode_i = '0;
  logic [PW-1:0] d_payload_i = '0;
  logic [SW-1:0] q_status_o;
  logic [IW-1:0] q_icode_o;
  logic [PW-1:0] q_payload_o;
  logic empty_o;

  always #(CLK_P/2) clk = ~clk;

  stage_slot_reg #(
    .PAYLOAD_W(PW), .ICODE_W(IW), .STAT_W(SW),
    .STAT_BUBBLE(S_BUB), .ICODE_NOP(I_NOP), .VOID_PAYLOAD(P_VOID),
    .INIT_STATUS(S_INIT), .INIT_ICODE(I_INIT), .INIT_PAYLOAD(P_INIT)
  ) u0 (
    .clk(clk), .rst(rst), .stall_i(stall_i), .bubble_i(bubble_i), .init_i(init_i),
    .d_status_i(d_status_i), .d_icode_i(d_icode_i), .d_payload_i(d_payload_i),
    .q_status_o(q_status_o), .q_icode_o(q_icode_o), .q_payload_o(q_payload_o),
    .empty_o(empty_o)
  );

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  item_t sb[$];
  logic [W-1:0] model = '0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Driver: sets inputs at the falling edge and queues the expected slot word.
  task automatic step(input logic r, input logic s, input logic b, input logic i,
                      input logic [SW-1:0] st, input logic [IW-1:0] ic,
                      input logic [PW-1:0] pl, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; stall_i = s; bubble_i = b; init_i = i;
    d_status_i = st; d_icode_i = ic; d_payload_i = pl;
    if (r)      model = VOID_W;
    else if (i) model = PRIME_W;
    else if (b) model = VOID_W;
    else if (s) model = model;
    else        model = {st, ic, pl};
    it.exp = model;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: after each rising edge, compares outputs with the oldest entry.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        logic [W-1:0] got;
        logic exp_empty;
        it = sb.pop_front();
        got = {q_status_o, q_icode_o, q_payload_o};
        checks++;
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s: slot got %h expected %h", it.tag, got, it.exp);
        end
        exp_empty = (it.exp[W-1 -: SW] == S_BUB);
        checks++;
        if (empty_o !== exp_empty) begin
          fails++;
          $display("FAIL R7 (%s): empty got %b expected %b", it.tag, empty_o, exp_empty);
        end
      end
    end
  end

  initial begin
    step(1, 0, 0, 0, 2'd1, 4'h7, 12'h111, "R1 reset");
    step(1, 0, 0, 0, 2'd3, 4'hF, 12'hFFF, "R1 reset held");
    step(0, 0, 0, 0, 2'd1, 4'h3, 12'h123, "R2 capture a");
    step(0, 0, 0, 0, 2'd3, 4'hC, 12'hFED, "R2 capture b");
    step(0, 0, 0, 0, 2'd0, 4'h0, 12'h000, "R2 capture zero");
    step(0, 0, 0, 0, 2'd1, 4'h9, 12'h0F0, "R2 capture c");
    step(0, 1, 0, 0, 2'd3, 4'h6, 12'hBAD, "R3 stall ignores input");
    step(0, 1, 0, 0, 2'd0, 4'h2, 12'h777, "R3 stall second cycle");
    step(0, 0, 1, 0, 2'd1, 4'h4, 12'h444, "R4 bubble");
    step(0, 1, 0, 0, 2'd1, 4'h4, 12'h555, "R3 stall keeps empty");
    step(0, 0, 0, 0, 2'd1, 4'hA, 12'h246, "R2 capture after empty");
    step(0, 1, 1, 0, 2'd3, 4'hB, 12'h999, "R5 bubble beats stall");
    step(0, 0, 0, 0, S_BUB, 4'h8, 12'h808, "R7 captured empty status");
    step(0, 0, 0, 1, 2'd1, 4'hE, 12'hE0E, "R6 init");
    step(0, 0, 0, 0, 2'd3, 4'hD, 12'h0DD, "R2 capture after init");
    step(0, 1, 1, 1, 2'd1, 4'h7, 12'h700, "R6 init beats bubble and stall");
    step(0, 1, 0, 1, 2'd1, 4'h7, 12'h701, "R6 init beats stall");
    step(0, 0, 0, 0, 2'd1, 4'h2, 12'h321, "R2 capture d");
    step(1, 0, 0, 1, 2'd1, 4'h2, 12'h321, "R8 reset beats init");
    step(0, 0, 0, 0, 2'd3, 4'h6, 12'h654, "R2 capture after reset");
    step(0, 0, 0, 0, 2'd3, 4'h6, 12'h654, "R2 idle repeat");
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 2000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule